// File: doc/BRIEF.md
# I2C Master Address Phase Sequencer

This block is the front end of an I2C master transmitter. Software asks for a START through a control register. The block then drives the open-drain SCL and SDA lines to produce the START. After that it sends one of two things: a 7-bit address byte, or the header and low byte of a 10-bit address. It samples the acknowledge bit after every byte.

Each step raises a status flag. While a flag is pending, SCL is held low and the bus does nothing. The flag clears only when software performs a fixed register access sequence, and that same sequence lets the next byte, or the STOP, proceed.

Bus timing comes from a programmable divider register. The block also watches the bus lines, so it can report whether the bus is busy.

Reads have side effects only when `reg_rd` is pulsed. The read data bus is combinational on `reg_addr`, so a read without `reg_rd` has no effect.

Register map:
- Address 0, control: bit 0 requests a START, bit 1 requests a STOP.
- Address 1, data.
- Address 2, status 0: bit 0 start-sent, bit 1 address-sent, bit 2 header-sent, bit 3 acknowledge-failure.
- Address 3, status 1: bit 0 master, bit 1 bus-busy.
- Address 4, divider.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset, both line drivers are released (`scl_oe`=0, `sda_oe`=0). Status 0, status 1 and control read 0, and the divider reads the `DIV_RST` value (4).
- R2: A control write with bit 0 set, while the block is idle, produces one START: SDA falls while SCL is high. The block then sets start-sent (status 0 bit 0) and master (status 1 bit 0). The bus-busy bit (status 1 bit 1) reads 1 once a START has been seen on the lines.
- R3: Start-sent clears only on a status 0 read (`reg_rd`) followed by a data write; that data byte is then shifted out. A data write with no preceding status 0 read is ignored. While any of start-sent, header-sent or address-sent is pending, SCL is held low.
- R4: Bytes are sent MSB first, and the slave's ACK is sampled on the ninth clock. A first byte whose top five bits are not 11110 is a complete 7-bit address: when it is acknowledged, address-sent (status 0 bit 1) is set and header-sent stays 0.
- R5: Address-sent clears on a status 0 read followed by a status 1 read. A status 1 read with no preceding status 0 read leaves it set.
- R6: A first byte whose top five bits are 11110 is a 10-bit header; when it is acknowledged, header-sent (status 0 bit 2) is set. A status 0 read followed by a data write then clears header-sent and sends the written low byte. Address-sent is set when that byte is acknowledged.
- R7: A NACK on an address or header byte sets acknowledge-failure (status 0 bit 3). The block then issues a STOP and returns to slave state (master 0). Acknowledge-failure clears on the next control write that requests a START.
- R8: SCL high and low phases of every address bit each last max(divider, 2) system clocks.
- R9: SDA changes while SCL is released only to form the START and the STOP. Each transaction therefore shows exactly one START and one STOP on the bus.
- R10: A control write with bit 1 set, while SCL is held, produces a STOP. Master drops to 0, and bus-busy drops to 0 once the STOP is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with the default `DIV_RST` of 4 and two synchronizer stages, then reprograms the divider at run time. A divider of 6 shows that the bit timing follows the register. A divider of 1 exercises the lower clamp of two cycles. The bench contains a slave model that can acknowledge or refuse, which reaches both the NACK-to-STOP path and the 10-bit header path without a second build.

// File: rtl/i2c_aseq_pkg.sv
package i2c_aseq_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_DATA  = 3'd1;
  localparam logic [REG_AW-1:0] RA_STAT0 = 3'd2;
  localparam logic [REG_AW-1:0] RA_STAT1 = 3'd3;
  localparam logic [REG_AW-1:0] RA_DIV   = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STA_A, ST_STA_B, ST_BIT_LO, ST_BIT_HI,
    ST_HOLD, ST_STO_A, ST_STO_B, ST_STO_C
  } seq_state_t;

  // A first byte with 11110 in its top five bits opens a 10-bit address.
  function automatic logic is_ten_bit_header(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:BYTE_W-5] == 5'b11110;
  endfunction
endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] lim,
  output logic          first,
  output logic          last
);
  // Phases shorter than two cycles would let SDA move on an SCL edge.
  function automatic logic [CW-1:0] phase_len(input logic [CW-1:0] v);
    return (v < CW'(2)) ? CW'(2) : v;
  endfunction

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == phase_len(lim) - CW'(1));
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  localparam int N = (SYNC_N < 2) ? 2 : SYNC_N;

  logic [N-1:0] scl_sh, sda_sh;
  logic         scl_p, sda_p;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh[g] <= 1'b1;
          sda_sh[g] <= 1'b1;
        end else begin
          scl_sh[g] <= (g == 0) ? scl_in : scl_sh[(g == 0) ? 0 : g-1];
          sda_sh[g] <= (g == 0) ? sda_in : sda_sh[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  logic start_ev, stop_ev;
  assign start_ev = scl_p && scl_sh[N-1] && sda_p && !sda_sh[N-1];
  assign stop_ev  = scl_p && scl_sh[N-1] && !sda_p && sda_sh[N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_p <= scl_sh[N-1];
      sda_p <= sda_sh[N-1];
      if (start_ev)     busy <= 1'b1;
      else if (stop_ev) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_aseq_pkg::*;
#(
  parameter int DIV_RST = 4,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam logic [3:0] ACK_BIT = 4'(BYTE_W);

  seq_state_t        state_q, state_d;
  logic [BYTE_W-1:0] sh_q;
  logic [3:0]        bitn_q;
  logic              in_hdr_q, sda_drv_q;
  logic              sb_q, hs_q, as_q, af_q, arm_q;
  logic              master_q, start_req_q, stop_req_q;
  logic [BYTE_W-1:0] div_q;
  logic              bus_busy, tm_first, tm_last;

  // Named events, also watched by the checker.
  logic wr_ctrl_ev, wr_data_ev, wr_div_ev, rd_stat0_ev, rd_stat1_ev;
  logic flag_pend, go_byte, addr_clr, stop_take, cond_phase;
  logic ack_done, nack, ack_ok;

  assign wr_ctrl_ev  = reg_wr && reg_addr == RA_CTRL;
  assign wr_data_ev  = reg_wr && reg_addr == RA_DATA;
  assign wr_div_ev   = reg_wr && reg_addr == RA_DIV;
  assign rd_stat0_ev = reg_rd && reg_addr == RA_STAT0;
  assign rd_stat1_ev = reg_rd && reg_addr == RA_STAT1;

  assign flag_pend  = sb_q || hs_q || as_q;
  assign stop_take  = (state_q == ST_HOLD) && stop_req_q;
  assign go_byte    = (state_q == ST_HOLD) && !stop_req_q && wr_data_ev && arm_q && (sb_q || hs_q);
  assign addr_clr   = rd_stat1_ev && arm_q && as_q;
  assign cond_phase = (state_q == ST_STA_A) || (state_q == ST_STO_C);
  assign ack_done   = (state_q == ST_BIT_HI) && tm_last && (bitn_q == ACK_BIT);
  assign nack       = ack_done && sda_i;
  assign ack_ok     = ack_done && !sda_i;

  i2c_phase_timer #(.CW(BYTE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(state_d != state_q),
    .lim(div_q), .first(tm_first), .last(tm_last)
  );

  i2c_bus_watch #(.SYNC_N(SYNC_N)) u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i), .busy(bus_busy)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_req_q && !bus_busy) state_d = ST_STA_A;
      ST_STA_A:  if (tm_last) state_d = ST_STA_B;
      ST_STA_B:  if (tm_last) state_d = ST_HOLD;
      ST_BIT_LO: if (tm_last) state_d = ST_BIT_HI;
      ST_BIT_HI: if (tm_last) begin
                   if (bitn_q != ACK_BIT) state_d = ST_BIT_LO;
                   else if (sda_i)        state_d = ST_STO_A;
                   else                   state_d = ST_HOLD;
                 end
      ST_HOLD:   if (stop_req_q) state_d = ST_STO_A;
                 else if (go_byte) state_d = ST_BIT_LO;
      ST_STO_A:  if (tm_last) state_d = ST_STO_B;
      ST_STO_B:  if (tm_last) state_d = ST_STO_C;
      ST_STO_C:  if (tm_last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q <= '0;
      bitn_q <= '0;
      in_hdr_q <= 1'b0;
      sda_drv_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tm_first) begin
        unique case (state_q)
          ST_STA_A:  sda_drv_q <= 1'b1;
          ST_BIT_LO: sda_drv_q <= (bitn_q != ACK_BIT) ? ~sh_q[BYTE_W-1] : 1'b0;
          ST_STO_A:  sda_drv_q <= 1'b1;
          ST_STO_C:  sda_drv_q <= 1'b0;
          default:   sda_drv_q <= sda_drv_q;
        endcase
      end
      if (go_byte) begin
        sh_q     <= reg_wdata;
        bitn_q   <= '0;
        in_hdr_q <= sb_q && is_ten_bit_header(reg_wdata);
      end else if (state_q == ST_BIT_HI && tm_last && bitn_q != ACK_BIT) begin
        sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
        bitn_q <= bitn_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q <= 1'b0; hs_q <= 1'b0; as_q <= 1'b0; af_q <= 1'b0; arm_q <= 1'b0;
      master_q <= 1'b0; start_req_q <= 1'b0; stop_req_q <= 1'b0;
      div_q <= BYTE_W'(DIV_RST);
    end else begin
      if (wr_div_ev) div_q <= reg_wdata;

      if (state_q == ST_IDLE && state_d == ST_STA_A) start_req_q <= 1'b0;
      else if (wr_ctrl_ev && reg_wdata[0] && state_q == ST_IDLE) start_req_q <= 1'b1;

      if (stop_take) stop_req_q <= 1'b0;
      else if (wr_ctrl_ev && reg_wdata[1] && state_q == ST_HOLD) stop_req_q <= 1'b1;

      if (state_q == ST_IDLE && state_d == ST_STA_A) master_q <= 1'b1;
      else if (state_q == ST_STO_C && tm_last)     master_q <= 1'b0;

      if (state_q == ST_STA_B && tm_last) sb_q <= 1'b1;
      else if (stop_take || (go_byte && sb_q)) sb_q <= 1'b0;

      if (ack_ok && in_hdr_q) hs_q <= 1'b1;
      else if (stop_take || (go_byte && hs_q)) hs_q <= 1'b0;

      if (ack_ok && !in_hdr_q) as_q <= 1'b1;
      else if (stop_take || addr_clr) as_q <= 1'b0;

      if (nack) af_q <= 1'b1;
      else if (wr_ctrl_ev && reg_wdata[0]) af_q <= 1'b0;

      if (stop_take || go_byte || addr_clr) arm_q <= 1'b0;
      else if (rd_stat0_ev && flag_pend)    arm_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_CTRL:  reg_rdata = {{(BYTE_W-2){1'b0}}, stop_req_q, start_req_q};
      RA_DATA:  reg_rdata = sh_q;
      RA_STAT0: reg_rdata = {{(BYTE_W-4){1'b0}}, af_q, hs_q, as_q, sb_q};
      RA_STAT1: reg_rdata = {{(BYTE_W-2){1'b0}}, bus_busy, master_q};
      RA_DIV:   reg_rdata = div_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign scl_oe = (state_q == ST_STA_B) || (state_q == ST_BIT_LO) ||
                  (state_q == ST_HOLD)  || (state_q == ST_STO_A);
  assign sda_oe = sda_drv_q;
endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic cond_phase,
  input logic sb,
  input logic hs,
  input logic as_f,
  input logic master,
  input logic wr_data_ev,
  input logic rd_stat1_ev,
  input logic stop_take
);
  p_flag_holds_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sb || hs || as_f) |-> scl_oe);

  p_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sb, hs, as_f}));

  p_sda_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !cond_phase) |-> $stable(sda_oe));

  p_sb_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sb) |-> ($past(wr_data_ev) || $past(stop_take)));

  p_as_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_f) |-> ($past(rd_stat1_ev) || $past(stop_take)));

  p_master_with_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sb || hs || as_f) |-> master);
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .cond_phase(cond_phase), .sb(sb_q), .hs(hs_q), .as_f(as_q),
  .master(master_q), .wr_data_ev(wr_data_ev), .rd_stat1_ev(rd_stat1_ev),
  .stop_take(stop_take)
);

// File: tb/i2c_addr_seq_bench.sv
module i2c_addr_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, scl_i, sda_i;
  logic       pull = 1'b0;
  logic       ack_en = 1'b1;

  int checks = 0, failures = 0;
  int starts = 0, stops = 0, rcount = 0, hcnt = 0, lcnt = 0;
  int last_hi = 0, last_lo = 0, scl_hi_seen = 0;
  logic [7:0] cap = 8'd0, last_byte = 8'd0;
  logic scl_p = 1'b1, sda_p = 1'b1;

  always #4 clk = ~clk;

  assign scl_i = ~scl_oe;
  assign sda_i = ~(sda_oe | pull);

  i2c_addr_seq u_i2c_addr_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // Slave model and line observer, evaluated away from the active edge.
  always @(negedge clk) begin
    if (scl_i) scl_hi_seen = scl_hi_seen + 1;
    if (scl_p && scl_i && sda_p && !sda_i) begin
      starts = starts + 1; rcount = 0; pull = 1'b0;
    end else if (scl_p && scl_i && !sda_p && sda_i) begin
      stops = stops + 1; rcount = 0; pull = 1'b0;
    end else if (!scl_p && scl_i) begin
      if (rcount < 8) cap = {cap[6:0], sda_i};
      rcount = rcount + 1;
      if (rcount == 8) last_byte = cap;
      last_lo = lcnt; hcnt = 1;
    end else if (scl_p && !scl_i) begin
      last_hi = hcnt; lcnt = 1;
      if (rcount == 8) pull = ack_en;
      else if (rcount == 9) begin pull = 1'b0; rcount = 0; end
    end else begin
      if (scl_i) hcnt = hcnt + 1; else lcnt = lcnt + 1;
    end
    scl_p = scl_i;
    sda_p = sda_i;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_bit(input logic [2:0] a, input int b, input logic val, input string tag);
    logic [7:0] v;
    int n;
    n = 0;
    @(negedge clk);
    while (n < 4000) begin
      peek(a, v);
      if (v[b] == val) break;
      n++;
      @(negedge clk);
    end
    chk(n < 4000, tag, v[b], val);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(3'd2, v); chk(v == 8'h00, "R1 status0", v, 0);
    peek(3'd3, v); chk(v == 8'h00, "R1 status1", v, 0);
    peek(3'd0, v); chk(v == 8'h00, "R1 control", v, 0);
    peek(3'd4, v); chk(v == 8'd4, "R1 divider", v, 4);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_seven_bit;
    logic [7:0] v;
    int s0, p0, hi0;
    s0 = starts; p0 = stops;
    reg_write(3'd0, 8'h01);
    wait_bit(3'd2, 0, 1'b1, "R2 start-sent");
    peek(3'd3, v); chk(v[1:0] == 2'b11, "R2 master and busy", v[1:0], 3);
    chk(starts == s0 + 1, "R2 one START", starts - s0, 1);
    // R3: a data write without a status 0 read is ignored; SCL stays low.
    reg_write(3'd1, 8'h55);
    hi0 = scl_hi_seen;
    repeat (40) @(negedge clk);
    chk(scl_hi_seen == hi0, "R3 SCL held", scl_hi_seen - hi0, 0);
    peek(3'd2, v); chk(v[0] == 1'b1, "R3 start-sent kept", v[0], 1);
    reg_read(3'd2, v);
    reg_write(3'd1, 8'hA4);
    wait_bit(3'd2, 1, 1'b1, "R4 address-sent");
    chk(last_byte == 8'hA4, "R4 byte on bus", last_byte, 8'hA4);
    peek(3'd2, v); chk(v[2] == 1'b0 && v[0] == 1'b0, "R4 no header flag", v, 2);
    chk(last_hi == 4 && last_lo == 4, "R8 phases div 4", {last_hi[7:0], last_lo[7:0]}, 16'h0404);
    // R5: a status 1 read alone does not clear address-sent.
    reg_read(3'd3, v);
    peek(3'd2, v); chk(v[1] == 1'b1, "R5 stat1-only kept", v[1], 1);
    reg_read(3'd2, v);
    reg_read(3'd3, v);
    peek(3'd2, v); chk(v[1] == 1'b0, "R5 address-sent cleared", v[1], 0);
    // R10: STOP request from the held state.
    reg_write(3'd0, 8'h02);
    wait_bit(3'd3, 0, 1'b0, "R10 master drops");
    repeat (10) @(negedge clk);
    peek(3'd3, v); chk(v[1] == 1'b0, "R10 bus idle", v[1], 0);
    chk(scl_i && sda_i, "R10 lines high", {scl_i, sda_i}, 3);
    chk(starts == s0 + 1 && stops == p0 + 1, "R9 one START one STOP",
        (starts - s0) * 16 + (stops - p0), 17);
  endtask

  task automatic t_ten_bit;
    logic [7:0] v;
    reg_write(3'd4, 8'd6);
    reg_write(3'd0, 8'h01);
    wait_bit(3'd2, 0, 1'b1, "R2 start-sent 10b");
    reg_read(3'd2, v);
    reg_write(3'd1, 8'hF2);
    wait_bit(3'd2, 2, 1'b1, "R6 header-sent");
    peek(3'd2, v); chk(v[1] == 1'b0, "R6 no address-sent yet", v[1], 0);
    chk(last_byte == 8'hF2, "R6 header on bus", last_byte, 8'hF2);
    reg_read(3'd2, v);
    reg_write(3'd1, 8'h5C);
    wait_bit(3'd2, 1, 1'b1, "R6 address-sent after low byte");
    peek(3'd2, v); chk(v[2] == 1'b0, "R6 header-sent cleared", v[2], 0);
    chk(last_byte == 8'h5C, "R6 low byte on bus", last_byte, 8'h5C);
    chk(last_hi == 6 && last_lo == 6, "R8 phases div 6", {last_hi[7:0], last_lo[7:0]}, 16'h0606);
    reg_read(3'd2, v);
    reg_read(3'd3, v);
    reg_write(3'd0, 8'h02);
    wait_bit(3'd3, 0, 1'b0, "R10 master drops 10b");
    repeat (10) @(negedge clk);
  endtask

  task automatic t_nack;
    logic [7:0] v;
    int p0;
    p0 = stops;
    reg_write(3'd4, 8'd1);
    ack_en = 1'b0;
    reg_write(3'd0, 8'h01);
    wait_bit(3'd2, 0, 1'b1, "R2 start-sent nack");
    reg_read(3'd2, v);
    reg_write(3'd1, 8'h90);
    wait_bit(3'd3, 0, 1'b0, "R7 back to slave");
    peek(3'd2, v); chk(v[3] == 1'b1 && v[1] == 1'b0, "R7 ack-failure", v, 8);
    chk(last_hi == 2 && last_lo == 2, "R8 clamp to 2", {last_hi[7:0], last_lo[7:0]}, 16'h0202);
    repeat (10) @(negedge clk);
    chk(stops == p0 + 1, "R7 STOP issued", stops - p0, 1);
    peek(3'd3, v); chk(v[1] == 1'b0, "R7 bus idle", v[1], 0);
    ack_en = 1'b1;
    reg_write(3'd0, 8'h01);
    peek(3'd2, v); chk(v[3] == 1'b0, "R7 ack-failure cleared", v[3], 0);
    wait_bit(3'd2, 0, 1'b1, "R2 start-sent retry");
    reg_read(3'd2, v);
    reg_write(3'd1, 8'h20);
    wait_bit(3'd2, 1, 1'b1, "R4 address-sent retry");
    chk(last_byte == 8'h20, "R4 retry byte", last_byte, 8'h20);
    reg_read(3'd2, v);
    reg_read(3'd3, v);
    reg_write(3'd0, 8'h02);
    wait_bit(3'd3, 0, 1'b0, "R10 master drops retry");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_seven_bit;
    t_ten_bit;
    t_nack;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule